// File: doc/BRIEF.md
# Mailbox Command Issue Sequencer

This block is the host-side engine that feeds a command/response mailbox shared with an on-chip service engine. Requests arrive on a valid/ready stream and sit in a small input FIFO. The sequencer handles one request at a time. It stamps a sequence number into command word 0 and checks that the engine's doorbell is free. It then writes the four command words and rings the engine's doorbell. If the request asks for an answer, it waits for the engine's "response waiting" event under a timeout chosen by command class.

A response is read from the four response registers and checked against the sequence number that was sent. It then leaves on a valid/ready completion stream. The sequencer does not stall on a failure. A mailbox access error or an expired timeout sets the generic-error code in the primary status field of the completion. A sequence mismatch replaces the primary status with the sequence-error code. When the engine reports that it has come back from a reset, the command in flight is written out again with its original sequence number.

Back-pressure rules: `req_ready` is low only while the input FIFO is full, and a request is taken on any edge where `req_valid` and `req_ready` are both high. A completion is offered with `cpl_valid`. It stays unchanged until `cpl_ready` is sampled high. No further mailbox command is written until it is taken. Each mailbox access holds `mb_req` and its address and data steady until the edge where `mb_ack` is sampled high.

Top module: `mbx_issue_seq`

## Requirements
- R1: At most one command is in flight. No command word is written until the previous command has completed and its completion has been accepted. `req_ready` is low only when FIFO_DEPTH requests are waiting.
- R2: Command word 0 is {16'h0, flags[47:32], sequence[31:16], class[15:8], command[7:0]}. The sequence number starts at 1 after reset and advances by one for each issued command. After SEQ_MAX-1 it returns to 1, so 0 and SEQ_MAX never appear.
- R3: Before issuing, the engine doorbell (address 8) is read. While its bit 63 is set, no command word is written.
- R4: Issue writes addresses 0, 1, 2, 3 in that order and then writes 2^63 to the engine doorbell set alias (address 10). If flag bit 8 (0x0100) is clear, the completion word 0 is {32'h0, sequence, class, command} with words 1 to 3 zero.
- R5: Classes 0xD1, 0xD4, 0xD5, 0xD6 and 0xD7 wait SHORT_MS×TICKS_PER_MS cycles. Classes 0xD2 and 0xD3 wait LONG_MS×TICKS_PER_MS cycles. Any other class is not issued and completes with primary status 0x01 and sequence field 0.
- R6: When the wait expires without an event, the completion carries primary status 0xFE [63:48] and the stamped sequence, class and command.
- R7: On a "response waiting" event (host doorbell address 11, bit 63), response words are read from addresses 4 to 7 and returned as completion words 0 to 3. If the sequence field of the response differs from the one sent, primary status becomes 0x03.
- R8: On an "engine reset" event (host doorbell bit 60), the command in flight is written again with the same word 0, and the wait restarts.
- R9: After each host doorbell event, the sequencer writes a mask with bit 63 clear to the host doorbell clear alias (address 12). The mask also clears bit 60 after a reset event.
- R10: An error reported on any issue access ends the command at once, with primary status 0xFE, and the engine doorbell is not rung.
- R11: While `cpl_valid` is high and `cpl_ready` is low, `cpl_valid` and `cpl_data` stay unchanged.
- R12: After reset, `req_ready` is high and `cpl_valid` and `mb_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | request offered |
| req_ready | output | 1 | input FIFO has room |
| req_flags | input | 16 | control flags (bit 8: response required) |
| req_class | input | 8 | command class |
| req_cmd | input | 8 | command code |
| req_args | input | 192 | command words 1..3, word 1 in bits [63:0] |
| mb_req | output | 1 | mailbox access request |
| mb_we | output | 1 | access is a write |
| mb_addr | output | 4 | mailbox register index |
| mb_wdata | output | 64 | write data |
| mb_ack | input | 1 | access done |
| mb_err | input | 1 | access failed (valid with mb_ack) |
| mb_rdata | input | 64 | read data (valid with mb_ack) |
| db_irq | input | 1 | host doorbell has an event |
| cpl_valid | output | 1 | completion offered |
| cpl_ready | input | 1 | completion taken |
| cpl_data | output | 256 | completion words 0..3, word 0 in bits [63:0] |

## Verification
A timeout completion must rise exactly N+2 cycles after the mailbox model records the doorbell ring, where N is the class wait in cycles. The bench counts falling edges from the first one on which the ring is visible. It checks that `cpl_valid` is still low at N+1 and high at N+2, for one short and one long class. Other results depend on how many cycles the mailbox model takes to answer, so the bench does not count cycles for them. It waits for the event itself: the ring in the model's engine doorbell, or `cpl_valid`. It then compares data, and it checks write ordering through a log of mailbox writes. Inputs change and outputs are read only on falling edges, or one time unit after a rising edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DW     = 64;
  localparam int NWORDS = 4;

  // mailbox register indices (decoded by the mailbox block)
  localparam logic [3:0] A_ENG_RW   = 4'd8;
  localparam logic [3:0] A_ENG_OR   = 4'd10;
  localparam logic [3:0] A_HOST_RW  = 4'd11;
  localparam logic [3:0] A_HOST_AND = 4'd12;

  localparam int DB_MSG_BIT = 63;
  localparam int DB_RST_BIT = 60;
  localparam logic [DW-1:0] DB_MSG = 64'h8000_0000_0000_0000;
  localparam logic [DW-1:0] DB_RST = 64'h1000_0000_0000_0000;

  localparam logic [15:0] FLAG_RESP  = 16'h0100;
  localparam logic [15:0] ST_BADCLS  = 16'h0001;
  localparam logic [15:0] ST_SEQERR  = 16'h0003;
  localparam logic [15:0] ST_GENERIC = 16'h00FE;

  typedef enum logic [1:0] {K_BAD, K_SHORT, K_LONG} kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_POLL, S_WCMD, S_RING, S_WAIT, S_RDDB, S_RDRSP, S_CLR, S_CPL
  } state_e;

  typedef enum logic [1:0] {AFT_WAIT, AFT_REISSUE, AFT_DONE} after_e;

  function automatic kind_e class_kind(input logic [7:0] c);
    case (c)
      8'hD1, 8'hD4, 8'hD5, 8'hD6, 8'hD7: return K_SHORT;
      8'hD2, 8'hD3:                      return K_LONG;
      default:                           return K_BAD;
    endcase
  endfunction
endpackage

// File: rtl/mbx_req_fifo.sv
module mbx_req_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt == (AW+1)'(DEPTH));
  assign empty = (cnt == '0);
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/mbx_seq_ctr.sv
module mbx_seq_ctr #(
  parameter int SEQ_MAX = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  output logic [15:0] seq
);
  localparam logic [15:0] LAST = 16'(SEQ_MAX - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seq <= 16'd1;
    else if (adv)    seq <= (seq >= LAST) ? 16'd1 : seq + 16'd1;
  end
endmodule

// File: rtl/mbx_class_timer.sv
module mbx_class_timer #(
  parameter int TICKS_PER_MS = 1000,
  parameter int SHORT_MS     = 100,
  parameter int LONG_MS      = 30000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic is_long,
  input  logic run,
  output logic expired
);
  localparam int SHORT_N = SHORT_MS * TICKS_PER_MS;
  localparam int LONG_N  = LONG_MS * TICKS_PER_MS;
  localparam int CW      = $clog2(LONG_N + 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= is_long ? CW'(LONG_N) : CW'(SHORT_N);
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/mbx_issue_seq.sv
module mbx_issue_seq
  import mbx_pkg::*;
#(
  parameter int FIFO_DEPTH   = 2,
  parameter int TICKS_PER_MS = 1000,
  parameter int SHORT_MS     = 100,
  parameter int LONG_MS      = 30000,
  parameter int SEQ_MAX      = 16'hFFFF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [15:0]          req_flags,
  input  logic [7:0]           req_class,
  input  logic [7:0]           req_cmd,
  input  logic [3*DW-1:0]      req_args,
  output logic                 mb_req,
  output logic                 mb_we,
  output logic [3:0]           mb_addr,
  output logic [DW-1:0]        mb_wdata,
  input  logic                 mb_ack,
  input  logic                 mb_err,
  input  logic [DW-1:0]        mb_rdata,
  input  logic                 db_irq,
  output logic                 cpl_valid,
  input  logic                 cpl_ready,
  output logic [NWORDS*DW-1:0] cpl_data
);
  localparam int FW = 16 + 8 + 8 + 3*DW;

  state_e          state;
  after_e          after_q;
  logic [1:0]      idx;
  logic [DW-1:0]   cmd_q [NWORDS];
  logic [DW-1:0]   rsp_q [NWORDS];
  logic [DW-1:0]   clr_mask;
  logic            need_q, long_q;

  // input queue
  logic [FW-1:0]   head;
  logic            f_full, f_empty, f_pop;
  logic [15:0]     h_flags;
  logic [7:0]      h_class, h_cmd;
  logic [3*DW-1:0] h_args;
  kind_e           h_kind;

  assign req_ready = !f_full;
  assign f_pop     = (state == S_IDLE) && !f_empty;
  assign {h_flags, h_class, h_cmd, h_args} = head;
  assign h_kind    = class_kind(h_class);

  mbx_req_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (req_valid && !f_full),
    .pop   (f_pop),
    .wdata ({req_flags, req_class, req_cmd, req_args}),
    .rdata (head),
    .full  (f_full),
    .empty (f_empty)
  );

  // sequence stamping
  logic [15:0] seq_now;
  logic        seq_adv;
  assign seq_adv = f_pop && (h_kind != K_BAD);

  mbx_seq_ctr #(.SEQ_MAX(SEQ_MAX)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (seq_adv),
    .seq   (seq_now)
  );

  // per-class response wait
  logic tmr_load, tmr_exp;
  assign tmr_load = (state == S_RING) && mb_ack && !mb_err && need_q;

  mbx_class_timer #(
    .TICKS_PER_MS (TICKS_PER_MS),
    .SHORT_MS     (SHORT_MS),
    .LONG_MS      (LONG_MS)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .is_long (long_q),
    .run     (state == S_WAIT),
    .expired (tmr_exp)
  );

  // mailbox access decode
  always_comb begin
    mb_req   = 1'b1;
    mb_we    = 1'b0;
    mb_addr  = '0;
    mb_wdata = '0;
    case (state)
      S_POLL:  mb_addr = A_ENG_RW;
      S_WCMD:  begin mb_we = 1'b1; mb_addr = {2'b00, idx}; mb_wdata = cmd_q[idx]; end
      S_RING:  begin mb_we = 1'b1; mb_addr = A_ENG_OR;     mb_wdata = DB_MSG;     end
      S_RDDB:  mb_addr = A_HOST_RW;
      S_RDRSP: mb_addr = {2'b01, idx};
      S_CLR:   begin mb_we = 1'b1; mb_addr = A_HOST_AND;   mb_wdata = clr_mask;   end
      default: mb_req = 1'b0;
    endcase
  end

  assign cpl_valid = (state == S_CPL);

  generate
    for (genvar g = 0; g < NWORDS; g++) begin : g_cpl
      assign cpl_data[g*DW +: DW] = rsp_q[g];
    end
  endgenerate

  // sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      after_q  <= AFT_WAIT;
      idx      <= '0;
      clr_mask <= '0;
      need_q   <= 1'b0;
      long_q   <= 1'b0;
      for (int i = 0; i < NWORDS; i++) begin
        cmd_q[i] <= '0;
        rsp_q[i] <= '0;
      end
    end else begin
      case (state)
        S_IDLE: if (!f_empty) begin
          for (int i = 1; i < NWORDS; i++) begin
            cmd_q[i] <= h_args[(i-1)*DW +: DW];
            rsp_q[i] <= '0;
          end
          need_q <= (h_flags & FLAG_RESP) != 16'h0;
          long_q <= (h_kind == K_LONG);
          if (h_kind == K_BAD) begin
            cmd_q[0] <= '0;
            rsp_q[0] <= {ST_BADCLS, 16'h0, 16'h0, h_class, h_cmd};
            state    <= S_CPL;
          end else begin
            cmd_q[0] <= {16'h0, h_flags, seq_now, h_class, h_cmd};
            rsp_q[0] <= {32'h0, seq_now, h_class, h_cmd};
            state    <= S_POLL;
          end
        end

        S_POLL: if (mb_ack) begin
          if (mb_err) begin
            rsp_q[0][63:48] <= rsp_q[0][63:48] | ST_GENERIC;
            state <= S_CPL;
          end else if (!mb_rdata[DB_MSG_BIT]) begin
            idx   <= '0;
            state <= S_WCMD;
          end
        end

        S_WCMD: if (mb_ack) begin
          if (mb_err) begin
            rsp_q[0][63:48] <= rsp_q[0][63:48] | ST_GENERIC;
            state <= S_CPL;
          end else if (idx == 2'(NWORDS - 1)) begin
            state <= S_RING;
          end else begin
            idx <= idx + 1'b1;
          end
        end

        S_RING: if (mb_ack) begin
          if (mb_err) begin
            rsp_q[0][63:48] <= rsp_q[0][63:48] | ST_GENERIC;
            state <= S_CPL;
          end else begin
            state <= need_q ? S_WAIT : S_CPL;
          end
        end

        S_WAIT: begin
          if (db_irq) begin
            state <= S_RDDB;
          end else if (tmr_exp) begin
            rsp_q[0][63:48] <= rsp_q[0][63:48] | ST_GENERIC;
            state <= S_CPL;
          end
        end

        S_RDDB: if (mb_ack) begin
          clr_mask <= ~DB_MSG;
          if (mb_err) begin
            after_q <= AFT_WAIT;
            state   <= S_CLR;
          end else if (mb_rdata[DB_RST_BIT]) begin
            clr_mask <= ~(DB_MSG | DB_RST);
            after_q  <= AFT_REISSUE;
            state    <= S_CLR;
          end else if (mb_rdata[DB_MSG_BIT]) begin
            idx     <= '0;
            after_q <= AFT_DONE;
            state   <= S_RDRSP;
          end else begin
            after_q <= AFT_WAIT;
            state   <= S_CLR;
          end
        end

        S_RDRSP: if (mb_ack) begin
          if (mb_err) begin
            rsp_q[0][63:48] <= rsp_q[0][63:48] | ST_GENERIC;
            state <= S_CLR;
          end else begin
            rsp_q[idx] <= mb_rdata;
            if (idx == 2'(NWORDS - 1)) begin
              if (rsp_q[0][31:16] != cmd_q[0][31:16])
                rsp_q[0][63:48] <= ST_SEQERR;
              state <= S_CLR;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end

        S_CLR: if (mb_ack) begin
          case (after_q)
            AFT_REISSUE: state <= S_POLL;
            AFT_DONE:    state <= S_CPL;
            default:     state <= S_WAIT;
          endcase
        end

        S_CPL: if (cpl_ready) state <= S_IDLE;

        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbx_issue_seq_chk.sv
module mbx_issue_seq_chk
  import mbx_pkg::*;
#(
  parameter int SEQ_MAX = 16'hFFFF
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mb_req,
  input logic                 mb_we,
  input logic [3:0]           mb_addr,
  input logic [DW-1:0]        mb_wdata,
  input logic                 mb_ack,
  input logic                 cpl_valid,
  input logic                 cpl_ready,
  input logic [NWORDS*DW-1:0] cpl_data
);
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req && !mb_ack |=> mb_req && $stable(mb_addr) && $stable(mb_we) && $stable(mb_wdata)); // R4
  AST_RING_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req && mb_we && mb_addr == A_ENG_OR |-> mb_wdata == DB_MSG); // R4
  AST_SEQ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req && mb_we && mb_addr == 4'd0 |-> mb_wdata[31:16] != 16'd0 && mb_wdata[31:16] < 16'(SEQ_MAX)); // R2
  AST_CLEAR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    mb_req && mb_we && mb_addr == A_HOST_AND |-> !mb_wdata[DB_MSG_BIT]); // R9
  AST_CPL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_data)); // R11
  AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> !(mb_req && mb_we && mb_addr[3:2] == 2'b00)); // R1
endmodule

bind mbx_issue_seq mbx_issue_seq_chk #(.SEQ_MAX(SEQ_MAX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mb_req    (mb_req),
  .mb_we     (mb_we),
  .mb_addr   (mb_addr),
  .mb_wdata  (mb_wdata),
  .mb_ack    (mb_ack),
  .cpl_valid (cpl_valid),
  .cpl_ready (cpl_ready),
  .cpl_data  (cpl_data)
);

// File: tb/sim_mbx_issue_seq.sv
`timescale 1ns/1ps
module sim_mbx_issue_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TPM        = 2;
  localparam int SEQ_MAX    = 5;
  localparam int SHORT_N    = 100 * TPM;
  localparam int LONG_N     = 30000 * TPM;
  localparam logic [63:0] BIT63 = 64'h8000_0000_0000_0000;
  localparam logic [63:0] BIT60 = 64'h1000_0000_0000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [15:0]  req_flags = '0;
  logic [7:0]   req_class = '0;
  logic [7:0]   req_cmd = '0;
  logic [191:0] req_args = '0;
  logic         mb_req, mb_we;
  logic [3:0]   mb_addr;
  logic [63:0]  mb_wdata;
  logic         mb_ack, mb_err;
  logic [63:0]  mb_rdata;
  logic         db_irq;
  logic         cpl_valid;
  logic         cpl_ready = 1'b0;
  logic [255:0] cpl_data;

  mbx_issue_seq #(.FIFO_DEPTH(2), .TICKS_PER_MS(TPM), .SHORT_MS(100),
                  .LONG_MS(30000), .SEQ_MAX(SEQ_MAX)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_flags(req_flags), .req_class(req_class), .req_cmd(req_cmd), .req_args(req_args),
    .mb_req(mb_req), .mb_we(mb_we), .mb_addr(mb_addr), .mb_wdata(mb_wdata),
    .mb_ack(mb_ack), .mb_err(mb_err), .mb_rdata(mb_rdata), .db_irq(db_irq),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_data(cpl_data));

  // mailbox model
  logic [63:0] regs [16];
  logic [3:0]  wlog_addr [16];
  logic [15:0] wr_cnt, w0_cnt;
  logic [63:0] last_w0;
  logic        poke_en = 1'b0;
  logic [3:0]  poke_addr = '0;
  logic [63:0] poke_data = '0;
  logic        err_en = 1'b0;
  logic [3:0]  err_addr = '0;

  assign db_irq = regs[11][63] | regs[11][60];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin regs[i] <= '0; wlog_addr[i] <= '0; end
      mb_ack <= 1'b0; mb_err <= 1'b0; mb_rdata <= '0;
      wr_cnt <= '0; w0_cnt <= '0; last_w0 <= '0;
    end else begin
      if (poke_en) regs[poke_addr] <= poke_data;
      if (mb_req && !mb_ack) begin
        mb_ack   <= 1'b1;
        mb_err   <= err_en && (mb_addr == err_addr);
        mb_rdata <= regs[mb_addr];
        if (mb_we) begin
          wlog_addr[wr_cnt[3:0]] <= mb_addr;
          wr_cnt <= wr_cnt + 16'd1;
          if (mb_addr == 4'd0) begin w0_cnt <= w0_cnt + 16'd1; last_w0 <= mb_wdata; end
          if (!(err_en && mb_addr == err_addr)) begin
            case (mb_addr)
              4'd9:    regs[8]  <= regs[8] & mb_wdata;
              4'd10:   regs[8]  <= regs[8] | mb_wdata;
              4'd12:   regs[11] <= regs[11] & mb_wdata;
              4'd13:   regs[11] <= regs[11] | mb_wdata;
              default: regs[mb_addr] <= mb_wdata;
            endcase
          end
        end
      end else begin
        mb_ack <= 1'b0;
        mb_err <= 1'b0;
      end
    end
  end

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_seq = 16'd1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mkw0(input logic [15:0] fl, input logic [15:0] sq,
                                       input logic [7:0] cl, input logic [7:0] cm);
    return {16'h0, fl, sq, cl, cm};
  endfunction

  function automatic logic [15:0] take_seq();
    logic [15:0] s = exp_seq;
    exp_seq = (exp_seq >= 16'(SEQ_MAX - 1)) ? 16'd1 : exp_seq + 16'd1;
    return s;
  endfunction

  task automatic push(input logic [15:0] fl, input logic [7:0] cl, input logic [7:0] cm,
                      input logic [191:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_flags = fl; req_class = cl; req_cmd = cm; req_args = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic poke(input logic [3:0] ad, input logic [63:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = ad; poke_data = d;
    @(posedge clk); #1;
    poke_en = 1'b0;
  endtask

  task automatic get_cpl(output logic [255:0] d);
    while (!cpl_valid) @(negedge clk);
    d = cpl_data;
    cpl_ready = 1'b1;
    @(negedge clk);
    cpl_ready = 1'b0;
  endtask

  task automatic wait_ring();
    do @(negedge clk); while (!regs[8][63]);
  endtask

  task automatic engine_reply(input logic [63:0] w0, input logic [63:0] w1,
                              input logic [63:0] w2, input logic [63:0] w3);
    wait_ring();
    poke(4'd4, w0); poke(4'd5, w1); poke(4'd6, w2); poke(4'd7, w3);
    poke(4'd8, 64'h0);
    poke(4'd11, BIT63);
  endtask

  task automatic t_reset();
    chk("R12 req_ready", 64'(req_ready), 64'd1);
    chk("R12 cpl_valid", 64'(cpl_valid), 64'd0);
    chk("R12 mb_req", 64'(mb_req), 64'd0);
  endtask

  task automatic t_noresp();
    logic [255:0] d;
    logic [15:0] s0 = wr_cnt;
    logic [15:0] sq = take_seq();
    push(16'h0000, 8'hD4, 8'h01, {64'hC3, 64'hB2, 64'hA1});
    get_cpl(d);
    chk("R4 write order", {44'h0, wlog_addr[s0[3:0]], wlog_addr[4'(s0+1)], wlog_addr[4'(s0+2)],
        wlog_addr[4'(s0+3)], wlog_addr[4'(s0+4)]}, {44'h0, 4'd0, 4'd1, 4'd2, 4'd3, 4'd10});
    chk("R2 word0 stamp", last_w0, mkw0(16'h0, sq, 8'hD4, 8'h01));
    chk("R2 word2", regs[2], 64'hB2);
    chk("R4 completion word0", d[63:0], {32'h0, sq, 8'hD4, 8'h01});
    chk("R4 completion words1-3", 64'(d[255:64] != '0), 64'd0);
    poke(4'd8, 64'h0);
  endtask

  task automatic t_resp_ok();
    logic [255:0] d;
    logic [15:0] sq = take_seq();
    logic [63:0] rw0 = {16'h0, 16'h0011, sq, 8'hD2, 8'h01};
    push(16'h0100, 8'hD2, 8'h01, '0);
    engine_reply(rw0, 64'h1111, 64'h2222, 64'h3333);
    while (!cpl_valid) @(negedge clk);
    d = cpl_data;
    repeat (5) @(negedge clk);
    chk("R11 held under back-pressure", 64'(cpl_valid && cpl_data == d), 64'd1);
    get_cpl(d);
    chk("R7 response word0", d[63:0], rw0);
    chk("R7 response word3", d[255:192], 64'h3333);
    chk("R9 response-waiting cleared", regs[11], 64'h0);
  endtask

  task automatic t_mismatch();
    logic [255:0] d;
    logic [15:0] sq = take_seq();
    push(16'h0100, 8'hD6, 8'h01, '0);
    engine_reply({16'h0, 16'h0042, 16'h0007, 8'hD6, 8'h01}, 64'h1, 64'h2, 64'h3);
    get_cpl(d);
    chk("R7 sequence mismatch status", d[63:0], {16'h0003, 16'h0042, 16'h0007, 8'hD6, 8'h01});
    chk("R7 sequence sent", 64'(last_w0[31:16]), 64'(sq));
  endtask

  task automatic t_busy();
    logic [255:0] d;
    logic [15:0] c0;
    logic [15:0] sq = take_seq();
    poke(4'd8, BIT63);
    c0 = w0_cnt;
    push(16'h0000, 8'hD1, 8'h02, '0);
    repeat (30) @(negedge clk);
    chk("R3 no issue while engine busy", 64'(w0_cnt), 64'(c0));
    poke(4'd8, 64'h0);
    get_cpl(d);
    chk("R3 issued once free", d[63:0], {32'h0, sq, 8'hD1, 8'h02});
    poke(4'd8, 64'h0);
  endtask

  task automatic t_wrap();
    logic [255:0] d;
    logic [15:0] sq = take_seq();
    push(16'h0000, 8'hD5, 8'h03, '0);
    get_cpl(d);
    chk("R2 sequence wraps to 1", 64'(last_w0[31:16]), 64'd1);
    chk("R2 expected seq", 64'(sq), 64'd1);
    poke(4'd8, 64'h0);
  endtask

  task automatic t_invalid();
    logic [255:0] d;
    logic [15:0] c0 = w0_cnt;
    push(16'h0100, 8'h55, 8'h09, '0);
    get_cpl(d);
    chk("R5 invalid class status", d[63:0], {16'h0001, 16'h0, 16'h0, 8'h55, 8'h09});
    chk("R5 invalid class not issued", 64'(w0_cnt), 64'(c0));
  endtask

  task automatic t_timeout(input logic [7:0] cl, input int n, input string tag);
    logic [255:0] d;
    logic [15:0] sq = take_seq();
    push(16'h0100, cl, 8'h04, '0);
    wait_ring();
    repeat (n + 1) @(negedge clk);
    chk({tag, " not before due cycle"}, 64'(cpl_valid), 64'd0);
    @(negedge clk);
    chk({tag, " due cycle"}, 64'(cpl_valid), 64'd1);
    get_cpl(d);
    chk("R6 timeout status", d[63:0], {16'h00FE, 16'h0, sq, cl, 8'h04});
    poke(4'd8, 64'h0);
  endtask

  task automatic t_reissue();
    logic [255:0] d;
    logic [15:0] c0;
    logic [15:0] sq = take_seq();
    push(16'h0100, 8'hD7, 8'h05, '0);
    wait_ring();
    c0 = w0_cnt;
    poke(4'd8, 64'h0);
    poke(4'd11, BIT60);
    wait_ring();
    chk("R8 command written again", 64'(w0_cnt), 64'(c0 + 16'd1));
    chk("R8 same word0", last_w0, mkw0(16'h0100, sq, 8'hD7, 8'h05));
    chk("R9 reset event cleared", regs[11], 64'h0);
    engine_reply({32'h0, sq, 8'hD7, 8'h05}, 64'h0, 64'h0, 64'h0);
    get_cpl(d);
    chk("R8 completes after reissue", d[63:0], {32'h0, sq, 8'hD7, 8'h05});
  endtask

  task automatic t_mb_err();
    logic [255:0] d;
    logic [15:0] s0 = wr_cnt;
    logic [15:0] sq = take_seq();
    err_en = 1'b1; err_addr = 4'd2;
    push(16'h0000, 8'hD4, 8'h06, '0);
    get_cpl(d);
    err_en = 1'b0;
    chk("R10 error status", d[63:0], {16'h00FE, 16'h0, sq, 8'hD4, 8'h06});
    chk("R10 no ring after error", 64'(wr_cnt - s0), 64'd3);
    chk("R10 engine doorbell untouched", regs[8], 64'h0);
  endtask

  task automatic t_inflight();
    logic [255:0] d;
    logic [15:0] c0;
    logic [15:0] s1 = take_seq();
    logic [15:0] s2 = take_seq();
    logic [15:0] s3 = take_seq();
    push(16'h0100, 8'hD5, 8'h01, '0);
    push(16'h0100, 8'hD6, 8'h02, '0);
    push(16'h0100, 8'hD4, 8'h03, '0);
    chk("R1 ready low when queue full", 64'(req_ready), 64'd0);
    wait_ring();
    c0 = w0_cnt;
    repeat (20) @(negedge clk);
    chk("R1 second command held back", 64'(w0_cnt), 64'(c0));
    engine_reply({32'h0, s1, 8'hD5, 8'h01}, 64'h0, 64'h0, 64'h0);
    get_cpl(d);
    chk("R1 first completion", d[63:0], {32'h0, s1, 8'hD5, 8'h01});
    engine_reply({32'h0, s2, 8'hD6, 8'h02}, 64'h0, 64'h0, 64'h0);
    get_cpl(d);
    chk("R1 second completion", d[63:0], {32'h0, s2, 8'hD6, 8'h02});
    engine_reply({32'h0, s3, 8'hD4, 8'h03}, 64'h0, 64'h0, 64'h0);
    get_cpl(d);
    chk("R1 third completion", d[63:0], {32'h0, s3, 8'hD4, 8'h03});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_noresp();
    t_resp_ok();
    t_mismatch();
    t_busy();
    t_wrap();
    t_invalid();
    t_timeout(8'hD1, SHORT_N, "R5 short wait");
    t_timeout(8'hD3, LONG_N, "R5 long wait");
    t_reissue();
    t_mb_err();
    t_inflight();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule